// File: doc/BRIEF.md
# Programmable Pulse-Per-Second Generator

This block turns a free-running time-of-day counter into a square wave. The counter is given as a whole-nanosecond word that wraps at a configurable rollover value and a 32-bit binary fraction of a nanosecond. The block does not divide a clock. It keeps its own threshold stamp. When the time reaches that stamp, the output level flips and the stamp moves forward by the step for the phase just entered. The high phase and the low phase each have their own fixed-point step, so the duty cycle is set by how the two steps compare. A period of 2·S with both steps equal to S gives a 50% square wave.

Software arms the generator in three moves. It programs the two steps, writes the threshold words, usually to zero, and sets the enable. While the enable is low, the output sits at its inactive level and the threshold stays where it is. A polarity bit inverts the pin.

A step may be longer than one second of the time counter. With the default parameters, a phase may last up to four rollover periods, which allows periods up to eight seconds. The block records how many rollovers the advanced threshold lies ahead and holds off comparison until the time counter has wrapped that many times. The time counter must pass every threshold value inside its second: its per-cycle advance may not be larger than the threshold resolution in use.

Top module: `pps_gen`

## Requirements
- R1: After synchronous reset the level is low, both threshold words are zero and nothing is pending. The pin therefore equals `pps_inv`, and the first enabled cycle with time at or above zero toggles the level.
- R2: While `pps_en` is low, the level is forced low at the next edge and the pin equals `pps_inv`. The threshold does not advance, so re-enabling resumes against the same threshold.
- R3: With `pps_en` high, no threshold write and nothing pending, the level toggles at the next clock edge when the unsigned 64-bit value {time_ns, time_frac} is greater than or equal to the threshold value {thr_ns, thr_frac}. In both values the nanosecond word is the upper 32 bits.
- R4: On a toggle, the threshold advances by `hi_step` when the new level is high and by `lo_step` when it is low. Each step holds whole nanoseconds in bits 63:32 and the fraction in bits 31:0. A carry from the fraction sum goes into the nanosecond sum.
- R5: The advanced nanosecond sum is reduced modulo ROLLOVER (up to MAX_WRAP subtractions). The number of subtractions is held pending, and comparison waits until that many time rollovers have been seen. A rollover is a cycle whose `time_ns` is below that of the previous cycle. The cycle of the last rollover already compares.
- R6: `thr_ns_we` loads `thr_wdata` into the nanosecond word and `thr_frac_we` loads it into the fraction word. Either write clears the pending count and applies from the next cycle. A write wins over a coinciding threshold hit: that cycle gives no toggle and no advance.
- R7: The pin is the level XOR `pps_inv`, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_en | input | 1 | Generator enable |
| pps_inv | input | 1 | Output polarity invert |
| time_ns | input | 32 | Time counter, nanoseconds within the current second |
| time_frac | input | 32 | Time counter, fractional nanoseconds |
| thr_wdata | input | 32 | Write data for a threshold word |
| thr_ns_we | input | 1 | Load threshold nanosecond word |
| thr_frac_we | input | 1 | Load threshold fraction word |
| hi_step | input | 64 | Step added when entering the high phase (ns in 63:32) |
| lo_step | input | 64 | Step added when entering the low phase (ns in 63:32) |
| pps_out | output | 1 | Pulse output pin |

## Verification
The two functions that can land in the same cycle are a software threshold write and a threshold hit. The bench provokes this by running its own absolute-time model one cycle ahead and issuing a nanosecond write, and later a fraction write, exactly in a cycle where the model predicts a toggle. It then expects the level to stay put and the new threshold to take over from the following cycle. A second collision, a hit in the same cycle as the rollover that drains the last pending wrap, comes up repeatedly in the step sweep. Steps there are long enough to wrap one to four seconds and land on a second boundary. The pin is judged against the model in every cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int NS_W    = 32;
    localparam int FRAC_W  = 32;
    localparam int STAMP_W = NS_W + FRAC_W;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } pps_stamp_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pps_phase_e;

    function automatic logic stamp_reached(pps_stamp_t now, pps_stamp_t thr);
        return {now.ns, now.frac} >= {thr.ns, thr.frac};
    endfunction

    function automatic pps_phase_e phase_flip(pps_phase_e ph);
        return (ph == PH_HIGH) ? PH_LOW : PH_HIGH;
    endfunction

endpackage

// File: rtl/pps_step_add.sv
module pps_step_add
    import pps_pkg::*;
#(
    parameter int unsigned ROLLOVER = 1000000000,
    parameter int          MAX_WRAP = 4,
    localparam int         WRAP_W   = $clog2(MAX_WRAP + 1)
) (
    input  pps_stamp_t          base,
    input  logic [STAMP_W-1:0]  step,
    output pps_stamp_t          next,
    output logic [WRAP_W-1:0]   wraps
);
    localparam int SUM_W = NS_W + 2;

    logic [FRAC_W:0]      frac_sum;
    logic [SUM_W-1:0]     ns_sum;
    logic [MAX_WRAP-1:0]  over;
    logic [SUM_W-1:0]     take;
    logic [SUM_W-1:0]     rem;

    assign frac_sum = {1'b0, base.frac} + {1'b0, step[FRAC_W-1:0]};
    assign ns_sum   = {2'b00, base.ns} + {2'b00, step[STAMP_W-1:FRAC_W]}
                    + {{(SUM_W-1){1'b0}}, frac_sum[FRAC_W]};

    // One comparator per whole rollover that the sum may cross.
    for (genvar k = 0; k < MAX_WRAP; k++) begin : g_over
        localparam logic [SUM_W-1:0] LIMIT = SUM_W'(64'(ROLLOVER) * 64'(k + 1));
        assign over[k] = (ns_sum >= LIMIT);
    end

    always_comb begin
        wraps = '0;
        for (int i = 0; i < MAX_WRAP; i++) begin
            wraps = wraps + WRAP_W'(over[i]);
        end
    end

    assign take      = SUM_W'(wraps) * SUM_W'(ROLLOVER);
    assign rem       = ns_sum - take;
    assign next.ns   = rem[NS_W-1:0];
    assign next.frac = frac_sum[FRAC_W-1:0];

endmodule

// File: rtl/pps_roll_watch.sv
module pps_roll_watch
    import pps_pkg::*;
#(
    parameter int WRAP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NS_W-1:0]   time_ns,
    input  logic              clr,
    input  logic              load,
    input  logic [WRAP_W-1:0] load_val,
    output logic              armed
);
    logic [NS_W-1:0]   prev_ns;
    logic [WRAP_W-1:0] pend;
    logic              roll;

    assign roll  = (time_ns < prev_ns);
    // The rollover that drains the last pending wrap already compares.
    assign armed = (pend == '0) || ((pend == WRAP_W'(1)) && roll);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ns <= '0;
            pend    <= '0;
        end else begin
            prev_ns <= time_ns;
            if (clr) begin
                pend <= '0;
            end else if (load) begin
                pend <= load_val;
            end else if (roll && (pend != '0)) begin
                pend <= pend - WRAP_W'(1);
            end
        end
    end

    // R5: each observed rollover drains one pending wrap
    p_drain_r5: assert property (@(posedge clk) disable iff (rst)
        (roll && (pend != '0) && !clr && !load) |=> (pend == $past(pend) - WRAP_W'(1)));

    // R6: a threshold write leaves nothing pending
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pend == '0));

endmodule

// File: rtl/pps_gen.sv
module pps_gen
    import pps_pkg::*;
#(
    parameter int unsigned ROLLOVER = 1000000000,
    parameter int          MAX_WRAP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pps_en,
    input  logic               pps_inv,
    input  logic [NS_W-1:0]    time_ns,
    input  logic [FRAC_W-1:0]  time_frac,
    input  logic [31:0]        thr_wdata,
    input  logic               thr_ns_we,
    input  logic               thr_frac_we,
    input  logic [STAMP_W-1:0] hi_step,
    input  logic [STAMP_W-1:0] lo_step,
    output logic               pps_out
);
    localparam int WRAP_W = $clog2(MAX_WRAP + 1);

    pps_stamp_t         thr_q;
    pps_stamp_t         now;
    pps_stamp_t         adv;
    pps_phase_e         phase_q;
    pps_phase_e         phase_nx;
    logic [STAMP_W-1:0] step_sel;
    logic [WRAP_W-1:0]  wraps;
    logic               wr;
    logic               armed;
    logic               hit;

    assign now.ns   = time_ns;
    assign now.frac = time_frac;
    assign wr       = thr_ns_we | thr_frac_we;
    assign phase_nx = phase_flip(phase_q);
    assign step_sel = (phase_nx == PH_HIGH) ? hi_step : lo_step;
    assign hit      = pps_en && !wr && armed && stamp_reached(now, thr_q);

    pps_step_add #(
        .ROLLOVER (ROLLOVER),
        .MAX_WRAP (MAX_WRAP)
    ) u_add (
        .base  (thr_q),
        .step  (step_sel),
        .next  (adv),
        .wraps (wraps)
    );

    pps_roll_watch #(
        .WRAP_W (WRAP_W)
    ) u_roll (
        .clk      (clk),
        .rst      (rst),
        .time_ns  (time_ns),
        .clr      (wr),
        .load     (hit),
        .load_val (wraps),
        .armed    (armed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q   <= '0;
            phase_q <= PH_LOW;
        end else begin
            if (thr_ns_we)   thr_q.ns   <= thr_wdata;
            if (thr_frac_we) thr_q.frac <= thr_wdata;
            if (hit)         thr_q      <= adv;

            if (!pps_en)  phase_q <= PH_LOW;
            else if (hit) phase_q <= phase_nx;
        end
    end

    assign pps_out = (phase_q == PH_HIGH) ^ pps_inv;

    // R2: disabled generator rests low
    p_rest_low_r2: assert property (@(posedge clk) disable iff (rst)
        !pps_en |=> (phase_q == PH_LOW));

    // R2: disabled generator keeps its threshold
    p_hold_thr_r2: assert property (@(posedge clk) disable iff (rst)
        (!pps_en && !wr) |=> $stable(thr_q));

    // R3: a hit flips the level
    p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (phase_q != $past(phase_q)));

    // R5: an in-range threshold stays in range after advancing
    p_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && (thr_q.ns < ROLLOVER)) |=> (thr_q.ns < ROLLOVER));

    // R6: a write wins over a hit, the level holds
    p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && pps_en) |=> $stable(phase_q));

    // R6: nanosecond write lands next cycle
    p_load_ns_r6: assert property (@(posedge clk) disable iff (rst)
        thr_ns_we |=> (thr_q.ns == $past(thr_wdata)));

endmodule

// File: tb/sim_pps_gen.sv
module sim_pps_gen;
    localparam int unsigned R    = 100;
    localparam int          MAXW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pps_en = 1'b0;
    logic        pps_inv = 1'b0;
    logic [31:0] time_ns = '0;
    logic [31:0] time_frac = '0;
    logic [31:0] thr_wdata = '0;
    logic        thr_ns_we = 1'b0;
    logic        thr_frac_we = 1'b0;
    logic [63:0] hi_step = '0;
    logic [63:0] lo_step = '0;
    logic        pps_out;

    always #4 clk = ~clk;

    pps_gen #(.ROLLOVER(R), .MAX_WRAP(MAXW)) u0 (
        .clk(clk), .rst(rst), .pps_en(pps_en), .pps_inv(pps_inv),
        .time_ns(time_ns), .time_frac(time_frac), .thr_wdata(thr_wdata),
        .thr_ns_we(thr_ns_we), .thr_frac_we(thr_frac_we),
        .hi_step(hi_step), .lo_step(lo_step), .pps_out(pps_out)
    );

    // Model in half-nanosecond units on an absolute, never-wrapping time axis.
    longint unsigned T     = 0;
    longint unsigned m_thr = 0;
    bit              m_lvl = 1'b0;
    longint unsigned cur_hi = 2;
    longint unsigned cur_lo = 2;
    int              checks = 0;
    int              errors = 0;
    bit              done_flag;

    function automatic logic [63:0] to_step(longint unsigned h);
        return {32'(h / 2), ((h % 2) != 0) ? 32'h8000_0000 : 32'h0};
    endfunction

    task automatic check_bit(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: pps_out=%0b expected %0b (T=%0d half-ns)", tag, got, exp, T);
        end
    endtask

    task automatic tick(input bit en, input bit inv, input bit nwe, input bit fwe,
                        input logic [31:0] wd, input string tag);
        longint unsigned base;
        @(negedge clk);
        check_bit(pps_out, m_lvl ^ pps_inv, tag);
        pps_en      = en;
        pps_inv     = inv;
        time_ns     = 32'((T / 2) % R);
        time_frac   = ((T % 2) != 0) ? 32'h8000_0000 : 32'h0;
        thr_ns_we   = nwe;
        thr_frac_we = fwe;
        thr_wdata   = wd;
        hi_step     = to_step(cur_hi);
        lo_step     = to_step(cur_lo);
        base = (T / (2 * R)) * (2 * R);
        if (nwe) m_thr = base + 2 * longint'(wd) + (m_thr % 2);
        if (fwe) m_thr = base + ((m_thr % (2 * R)) & ~64'd1) + longint'(wd[31]);
        if (!en) m_lvl = 1'b0;
        else if (!(nwe || fwe) && (T >= m_thr)) begin
            m_lvl = !m_lvl;
            m_thr = m_thr + (m_lvl ? cur_hi : cur_lo);
        end
        T++;
    endtask

    initial begin : watchdog
        repeat (198000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int hs [9] = '{2, 3, 5, 75, 199, 200, 201, 350, 800};
        string tag;
        // R1: reset state, both polarities
        repeat (3) @(negedge clk);
        check_bit(pps_out, 1'b0, "R1 reset level");
        pps_inv = 1'b1;
        @(negedge clk);
        check_bit(pps_out, 1'b1, "R1 R7 reset inverted");
        pps_inv = 1'b0;
        rst = 1'b0;

        // R1: reset threshold is zero, so the first enabled cycle toggles
        cur_hi = 20; cur_lo = 20;
        repeat (300) tick(1, 0, 0, 0, 0, "R1 R3 R4");

        // Sweep every pair of phase steps
        for (int a = 0; a < 9; a++) begin
            for (int b = 0; b < 9; b++) begin
                bit inv;
                inv = ((a + b) % 2) != 0;
                cur_hi = hs[a]; cur_lo = hs[b];
                while ((T % (2 * R)) != 0) tick(0, inv, 0, 0, 0, "R2 disabled");
                tick(0, inv, 1, 0, 0, "R2 R6");
                tick(0, inv, 0, 1, 0, "R2 R6");
                tag = inv ? "R3 R4 R5 R7" : "R3 R4 R5";
                repeat (1200) tick(1, inv, 0, 0, 0, tag);
            end
        end

        // R2: disable mid-run, threshold held across the pause
        cur_hi = 150; cur_lo = 150;
        while ((T % (2 * R)) != 0) tick(0, 0, 0, 0, 0, "R2");
        tick(0, 0, 1, 0, 0, "R6");
        tick(0, 0, 0, 1, 0, "R6");
        done_flag = 0;
        for (int i = 0; i < 3000 && !done_flag; i++) begin
            if (m_lvl && (m_thr > T + 24) && ((T % (2 * R)) < 2 * R - 30)) begin
                repeat (10) tick(0, 0, 0, 0, 0, "R2 pause");
                done_flag = 1;
            end else begin
                tick(1, 0, 0, 0, 0, "R3");
            end
        end
        checks++;
        if (!done_flag) begin errors++; $display("FAIL R2: pause window not reached (got 0 expected 1)"); end
        repeat (600) tick(1, 0, 0, 0, 0, "R2 resume");

        // R6: nanosecond write in a cycle that would toggle
        cur_hi = 6; cur_lo = 6;
        done_flag = 0;
        for (int i = 0; i < 3000 && !done_flag; i++) begin
            if ((T >= m_thr) && ((T % (2 * R)) >= 8) && ((T % (2 * R)) < 2 * R - 40)) begin
                tick(1, 0, 1, 0, 32'((T / 2) % R) + 32'd5, "R6 ns write vs hit");
                done_flag = 1;
            end else begin
                tick(1, 0, 0, 0, 0, "R3 R4");
            end
        end
        checks++;
        if (!done_flag) begin errors++; $display("FAIL R6: ns collision not reached (got 0 expected 1)"); end
        repeat (150) tick(1, 0, 0, 0, 0, "R6 after ns write");

        // R6: fraction write in a cycle that would toggle
        done_flag = 0;
        for (int i = 0; i < 3000 && !done_flag; i++) begin
            if ((T >= m_thr) && ((T % (2 * R)) >= 8) && ((T % (2 * R)) < 2 * R - 40)) begin
                tick(1, 1, 0, 1, 32'h8000_0000, "R6 R7 frac write vs hit");
                done_flag = 1;
            end else begin
                tick(1, 1, 0, 0, 0, "R3 R7");
            end
        end
        checks++;
        if (!done_flag) begin errors++; $display("FAIL R6: frac collision not reached (got 0 expected 1)"); end
        repeat (150) tick(1, 1, 0, 0, 0, "R6 R7 after frac write");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule